// File: doc/BRIEF.md
# PCI Bus-Master Address Window Translator

This block sits on the inbound side of a host bridge. Each address that a PCI bus master drives toward host memory is compared against a set of programmable windows. The default build has two windows. When an address lands inside an enabled window, the block claims the access and returns the host physical address it maps to. When no window claims the address, the block raises a no-claim flag so that the bridge can leave the cycle unanswered.

Each window is set up through three registers. The base register holds a 1 MB-aligned start address and a window-enable bit. The mask register holds the window size minus one, at 1 MB granularity. The translated-base register supplies the upper bits of the host address. Software writes and reads these registers through a simple port. A typical setup enables one window at 1 GB with a size of 1 GB and a translated base of zero, and leaves the other window switched off.

A decode takes one clock cycle. An address presented with `pci_valid_i` in one cycle gives a result on the outputs after the next rising edge. That result stays on the outputs until another decode replaces it.

Top module: `dmawin_xlate`

## Requirements
- R1: After reset, every configuration register reads zero, every window is disabled, and `hit_o` and `miss_o` are low.
- R2: Register address bits [1:0] select the register (0 = base, 1 = mask, 2 = translated base, 3 = reserved) and bits [2] select the window (0 = window 1, 1 = window 2). The base register reads back bits [31:20] and bit [19] as last written, with all other bits zero. The mask and translated-base registers read back bits [31:20] as last written, with all other bits zero. The reserved register always reads zero and ignores writes.
- R3: Bit [19] of a window's base register enables that window. A disabled window never claims an address, so writing zero to the base register turns the window off.
- R4: An address hits a window when the window is enabled and every address bit in [31:20] whose mask bit is clear equals the matching base bit.
- R5: On a hit, host address bits [31:20] take the translated-base bits where the mask bit is clear and the PCI address bits where the mask bit is set.
- R6: When more than one window hits, window 1 wins and `win_o` reads 0. A hit in window 2 alone gives `win_o` = 1.
- R7: A decode in which no window hits sets `miss_o` high and `hit_o` low. A cycle without `pci_valid_i` leaves both flags low after the next edge. The two flags are never high together.
- R8: The result of a decode appears one clock edge after `pci_valid_i`. A register write on one edge is already in use for a decode presented in the very next cycle.
- R9: On a hit, host address bits [19:0] equal PCI address bits [19:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select: {window, register} |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| pci_valid_i | input | 1 | A PCI address is presented for decode |
| pci_addr_i | input | 32 | PCI bus-master address |
| hit_o | output | 1 | Address claimed by a window |
| miss_o | output | 1 | Decode done and no window claimed the address |
| win_o | output | 1 | Index of the claiming window (0 = window 1) |
| host_addr_o | output | 32 | Translated host physical address |

## Verification
The decode path is exercised with four setups:
- The typical 1 GB window. Addresses just inside, just below and above it separate a correct mask comparison from a plain base compare.
- A 1 MB window with a non-zero translated base. This shows whether the upper bits really come from the translated base or pass straight through from the PCI address.
- Overlapping windows. These expose the priority order.
- A base written without the enable bit, and a base written to zero. These show that bit 19 alone gates the claim.

Register readback with all-ones data shows which bits are kept. A write followed at once by a decode pins down the one-edge timing.

// File: rtl/dmawin_pkg.sv
package dmawin_pkg;
  localparam int ADDR_W   = 32;
  localparam int GRAN_LSB = 20;
  localparam int EN_BIT   = 19;
  localparam int PAGE_W   = ADDR_W - GRAN_LSB;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_MASK = 2'd1,
    SEL_XLAT = 2'd2,
    SEL_RSVD = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic              en;
    logic [PAGE_W-1:0] base;
    logic [PAGE_W-1:0] mask;
    logic [PAGE_W-1:0] xlat;
  } win_cfg_t;
endpackage

// File: rtl/dmawin_regs.sv
module dmawin_regs
  import dmawin_pkg::*;
#(
  parameter int NUM_WIN   = 2,
  parameter int WIN_IDX_W = 1,
  parameter int REG_AW    = WIN_IDX_W + 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [REG_AW-1:0]   addr_i,
  input  logic [ADDR_W-1:0]   wdata_i,
  output logic [ADDR_W-1:0]   rdata_o,
  output win_cfg_t            cfg_o [NUM_WIN]
);
  reg_sel_e             sel;
  logic [WIN_IDX_W-1:0] idx;

  assign sel = reg_sel_e'(addr_i[1:0]);
  assign idx = addr_i[REG_AW-1:2];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_o[w] <= '0;
      end else if (we_i && idx == WIN_IDX_W'(w)) begin
        case (sel)
          SEL_BASE: begin
            cfg_o[w].base <= wdata_i[ADDR_W-1:GRAN_LSB];
            cfg_o[w].en   <= wdata_i[EN_BIT];
          end
          SEL_MASK: cfg_o[w].mask <= wdata_i[ADDR_W-1:GRAN_LSB];
          SEL_XLAT: cfg_o[w].xlat <= wdata_i[ADDR_W-1:GRAN_LSB];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (idx == WIN_IDX_W'(w)) begin
        case (sel)
          SEL_BASE: begin
            rdata_o[ADDR_W-1:GRAN_LSB] = cfg_o[w].base;
            rdata_o[EN_BIT]            = cfg_o[w].en;
          end
          SEL_MASK: rdata_o[ADDR_W-1:GRAN_LSB] = cfg_o[w].mask;
          SEL_XLAT: rdata_o[ADDR_W-1:GRAN_LSB] = cfg_o[w].xlat;
          default:  rdata_o = '0;
        endcase
      end
    end
  end

  assert_rsvd_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_RSVD) |-> (rdata_o == '0));

  assert_low_bits_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[EN_BIT-1:0] == '0);
endmodule

// File: rtl/dmawin_match.sv
module dmawin_match
  import dmawin_pkg::*;
(
  input  win_cfg_t            cfg_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic                hit_o,
  output logic [ADDR_W-1:0]   host_o
);
  logic [PAGE_W-1:0] page;
  logic [PAGE_W-1:0] diff;

  assign page  = addr_i[ADDR_W-1:GRAN_LSB];
  // compare only bits that are fixed by the window (mask clear)
  assign diff  = (page ^ cfg_i.base) & ~cfg_i.mask;
  assign hit_o = cfg_i.en && (diff == '0);

  assign host_o = {(cfg_i.xlat & ~cfg_i.mask) | (page & cfg_i.mask),
                   addr_i[GRAN_LSB-1:0]};
endmodule

// File: rtl/dmawin_xlate.sv
module dmawin_xlate
  import dmawin_pkg::*;
#(
  parameter int NUM_WIN = 2,
  localparam int WIN_IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int REG_AW    = WIN_IDX_W + 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic [REG_AW-1:0]    reg_addr_i,
  input  logic [ADDR_W-1:0]    reg_wdata_i,
  output logic [ADDR_W-1:0]    reg_rdata_o,
  input  logic                 pci_valid_i,
  input  logic [ADDR_W-1:0]    pci_addr_i,
  output logic                 hit_o,
  output logic                 miss_o,
  output logic [WIN_IDX_W-1:0] win_o,
  output logic [ADDR_W-1:0]    host_addr_o
);
  win_cfg_t             cfg      [NUM_WIN];
  logic [NUM_WIN-1:0]   match_v;
  logic [ADDR_W-1:0]    host_v   [NUM_WIN];
  logic                 any_hit;
  logic [WIN_IDX_W-1:0] sel_idx;

  dmawin_regs #(
    .NUM_WIN   (NUM_WIN),
    .WIN_IDX_W (WIN_IDX_W),
    .REG_AW    (REG_AW)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .cfg_o   (cfg)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
    dmawin_match u_match (
      .cfg_i  (cfg[w]),
      .addr_i (pci_addr_i),
      .hit_o  (match_v[w]),
      .host_o (host_v[w])
    );
  end

  // lowest index wins
  always_comb begin
    any_hit = 1'b0;
    sel_idx = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (match_v[w]) begin
        any_hit = 1'b1;
        sel_idx = WIN_IDX_W'(w);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o       <= 1'b0;
      miss_o      <= 1'b0;
      win_o       <= '0;
      host_addr_o <= '0;
    end else begin
      hit_o  <= pci_valid_i && any_hit;
      miss_o <= pci_valid_i && !any_hit;
      if (pci_valid_i && any_hit) begin
        win_o       <= sel_idx;
        host_addr_o <= host_v[sel_idx];
      end
    end
  end

  assert_flags_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && miss_o));

  assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pci_valid_i |=> (!hit_o && !miss_o));

  assert_one_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pci_valid_i |=> (hit_o || miss_o));

  assert_offset_pass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pci_valid_i |=> (!hit_o || host_addr_o[GRAN_LSB-1:0] == $past(pci_addr_i[GRAN_LSB-1:0])));

  assert_prio_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pci_valid_i && match_v[0]) |=> (hit_o && win_o == '0));

  assert_disabled_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pci_valid_i && !cfg[0].en && !cfg[NUM_WIN-1].en) |=> !hit_o);
endmodule

// File: tb/dmawin_xlate_test.sv
module dmawin_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pci_valid = 1'b0;
  logic [31:0] pci_addr = '0;
  logic        hit, miss;
  logic [0:0]  win;
  logic [31:0] host_addr;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  dmawin_xlate uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata),
    .pci_valid_i(pci_valid), .pci_addr_i(pci_addr),
    .hit_o(hit), .miss_o(miss), .win_o(win), .host_addr_o(host_addr)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_check(string req, logic [2:0] a, logic [31:0] exp);
    reg_addr = a;
    #1;
    check(req, "readback", reg_rdata, exp);
  endtask

  // decode one address, check outputs one edge later
  task automatic dec_check(string req, logic [31:0] a, logic e_hit,
                           logic e_win, logic [31:0] e_host);
    @(negedge clk);
    pci_valid = 1'b1; pci_addr = a;
    @(negedge clk);
    pci_valid = 1'b0;
    check(req, "hit", {31'd0, hit}, {31'd0, e_hit});
    check(req, "miss", {31'd0, miss}, {31'd0, ~e_hit});
    if (e_hit) begin
      check(req, "win", {31'd0, win}, {31'd0, e_win});
      check(req, "host", host_addr, e_host);
    end
  endtask

  task automatic t_reset;
    for (int a = 0; a < 8; a++) rd_check("R1", 3'(a), 32'h0);
    check("R1", "hit after reset", {31'd0, hit}, 32'd0);
    check("R1", "miss after reset", {31'd0, miss}, 32'd0);
    dec_check("R1", 32'h4000_0000, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic t_readback;
    wr(3'd0, 32'hFFFF_FFFF); rd_check("R2", 3'd0, 32'hFFF8_0000);
    wr(3'd1, 32'hFFFF_FFFF); rd_check("R2", 3'd1, 32'hFFF0_0000);
    wr(3'd2, 32'hFFFF_FFFF); rd_check("R2", 3'd2, 32'hFFF0_0000);
    wr(3'd3, 32'hFFFF_FFFF); rd_check("R2", 3'd3, 32'h0);
    wr(3'd6, 32'h1234_5678); rd_check("R2", 3'd6, 32'h1230_0000);
    rd_check("R2", 3'd2, 32'hFFF0_0000);
    wr(3'd0, 32'h0); wr(3'd1, 32'h0); wr(3'd2, 32'h0); wr(3'd6, 32'h0);
  endtask

  task automatic t_typical;
    wr(3'd0, 32'h4008_0000);
    wr(3'd1, 32'h3FF0_0000);
    wr(3'd2, 32'h0);
    dec_check("R4 R5 R9", 32'h4000_1234, 1'b1, 1'b0, 32'h0000_1234);
    dec_check("R5 R9", 32'h7FFF_FFFC, 1'b1, 1'b0, 32'h3FFF_FFFC);
    dec_check("R4 R7", 32'h3FFF_FFFC, 1'b0, 1'b0, 32'h0);
    dec_check("R4 R7", 32'h8000_0000, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic t_enable;
    wr(3'd0, 32'h4000_0000);
    dec_check("R3", 32'h4000_1234, 1'b0, 1'b0, 32'h0);
    wr(3'd0, 32'h4008_0000);
    dec_check("R3 R8", 32'h4000_1234, 1'b1, 1'b0, 32'h0000_1234);
    wr(3'd0, 32'h0);
    dec_check("R3 R8", 32'h4000_1234, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic t_window2;
    wr(3'd4, 32'h0088_0000);
    wr(3'd5, 32'h0);
    wr(3'd6, 32'h1230_0000);
    dec_check("R5 R6", 32'h008A_BCDE, 1'b1, 1'b1, 32'h123A_BCDE);
    dec_check("R4", 32'h009A_BCDE, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic t_priority;
    wr(3'd0, 32'h0008_0000);
    wr(3'd1, 32'hFFF0_0000);
    wr(3'd2, 32'h0);
    dec_check("R6", 32'h008A_BCDE, 1'b1, 1'b0, 32'h008A_BCDE);
  endtask

  task automatic t_idle;
    @(negedge clk);
    pci_valid = 1'b0; pci_addr = 32'h008A_BCDE;
    @(negedge clk);
    check("R7", "hit idle", {31'd0, hit}, 32'd0);
    check("R7", "miss idle", {31'd0, miss}, 32'd0);
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_readback();
    t_typical();
    t_enable();
    t_window2();
    t_priority();
    t_idle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule